// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

A 16-bit up-counter whose count pulses come from one of three clock sources: the system clock, the system clock divided by a fixed instruction-cycle ratio, or an external clock line. The external line is sampled into the system clock domain, with an optional second synchroniser stage. The chosen pulses pass through a 1/2/4/8 prescaler before they reach the counter. An optional gate qualifies counting. The gate can follow a pin, or an overflow or period-match pulse from a neighbouring timer, and its polarity is programmable.

The gate path has two acquisition modes for one-shot measurement. In toggle mode, the gate edges drive a flip-flop, so the counter runs for a whole gate period rather than for one level. In single-pulse mode, software arms one capture by writing a go bit. The capture starts on the next active gate edge. When the pulse ends, the go bit clears by itself and a sticky gate-event flag is raised. A wrap from all-ones to zero raises a sticky overflow flag. Software reads the counter one byte at a time, and a low-byte read freezes the high byte so that a 16-bit value can be read without tearing.

Top module: `gtmr16`

## Requirements
- R1: CTRL (address 0) bits [1:0] select the count source: 00 is the system clock divided by 4, 01 is the system clock, 10 is the external clock, and 11 is no source (the counter does not move). Bit 7 enables counting. With bit 7 clear the counter holds.
- R2: CTRL bits [3:2] select the prescaler ratio: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. The prescaler keeps its phase while counting is stopped.
- R3: The external clock advances the counter only on a rising edge that follows the first falling edge seen since counting was enabled. CTRL bit 4 adds a second synchroniser stage, which changes latency but not the count.
- R4: GATE (address 1) bit 7 enables gating, and bit 7 clear makes the gate inputs irrelevant. Bits [1:0] choose the gate: 00 is the pin, 01 is the overflow pulse, 10 is the match pulse and 11 is a constant low. Bit 2 set counts while the gate is low instead of high. A gate level held for K cycles adds K counts at ratio 1.
- R5: GATE bit 3 selects toggle mode. Each rising gate edge flips a flip-flop, and the counter counts while the flip-flop is set. Two gate edges P cycles apart therefore add P counts.
- R6: GATE bit 4 selects single-pulse mode. Writing 1 to GATE bit 5 (go) arms a capture, and writing 0 has no effect. Only the first full gated pulse after arming is counted. At its end, go reads 0 and the gate-event flag is set.
- R7: When the counter wraps from 0xFFFF to 0x0000 it sets the overflow flag. FLAGS (address 4) bit 0 is overflow and bit 1 is gate-event. Both flags stay set until a write with a 1 in that bit, and they also appear on ovf_flag_o and gate_evt_o.
- R8: GATE bit 6 reads the current qualified gate level.
- R9: The counter low byte is at address 2 and the high byte at address 3. A low-byte read copies the high byte into a buffer that later high-byte reads return. Read data appears on bus_rdata one cycle after bus_rd.
- R10: A write to either counter byte loads that byte and clears the prescaler and divider phase.
- R11: After reset all registers, the counter and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_clk_i | input | 1 | External count clock |
| gate_pin_i | input | 1 | Gate pin |
| tmr_ovf_evt_i | input | 1 | Overflow pulse from a neighbouring timer |
| tmr_match_evt_i | input | 1 | Period-match pulse from a neighbouring timer |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| gate_evt_o | output | 1 | Sticky gate-event flag |

## Verification
The hardest situation to reach is a single-pulse capture that has to ignore gate activity on both sides of the pulse it measures. The gate is already idle when go is armed, and a second pulse follows the capture. The stimulus arms go, confirms through a read that go is still set, and then drives one pin pulse of known width. It waits, drives a second, shorter pulse, and then checks that the count equals the first width alone, that go has cleared and that the event flag is set. The same window-counting method measures toggle mode from two one-cycle pulses spaced a known number of cycles apart on the neighbouring-timer line.

// File: rtl/gtmr16_pkg.sv
package gtmr16_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 3;

  typedef enum logic [1:0] {
    CLK_INSTR = 2'b00,
    CLK_SYS   = 2'b01,
    CLK_EXT   = 2'b10,
    CLK_NONE  = 2'b11
  } clk_sel_e;

  typedef enum logic [1:0] {
    GSRC_PIN   = 2'b00,
    GSRC_OVF   = 2'b01,
    GSRC_MATCH = 2'b10,
    GSRC_NONE  = 2'b11
  } gate_src_e;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_GATE = 3'd1;
  localparam logic [2:0] ADDR_CLO  = 3'd2;
  localparam logic [2:0] ADDR_CHI  = 3'd3;
  localparam logic [2:0] ADDR_FLAG = 3'd4;

  // Terminal prescaler count for a 2-bit ratio code: ratio 2**sel, limit ratio-1.
  function automatic logic [PRE_W-1:0] presc_limit(input logic [1:0] sel);
    logic [PRE_W:0] ratio;
    ratio = (PRE_W+1)'(1) << sel;
    return PRE_W'(ratio - (PRE_W+1)'(1));
  endfunction

  // True when one more increment wraps the counter.
  function automatic logic at_wrap(input logic [2*BYTE_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/gtmr16_clksrc.sv
module gtmr16_clksrc
  import gtmr16_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     sync_en,
  input  clk_sel_e sel,
  input  logic     adv,
  input  logic     clr,
  input  logic     ext_i,
  output logic     tick,
  output logic     ext_tick,
  output logic     armed
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic s1, s2, e_d, e_now, erise, efall;

  assign e_now = sync_en ? s2 : s1;
  assign erise = e_now & ~e_d;
  assign efall = ~e_now & e_d;
  assign ext_tick = erise & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      s1    <= 1'b0;
      s2    <= 1'b0;
      e_d   <= 1'b0;
      armed <= 1'b0;
    end else begin
      s1  <= ext_i;
      s2  <= s1;
      e_d <= e_now;
      armed <= run ? (armed | efall) : 1'b0;
      if (clr) div_q <= '0;
      else if (adv) div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  always_comb begin
    case (sel)
      CLK_INSTR: tick = (div_q == DIV_LAST);
      CLK_SYS:   tick = 1'b1;
      CLK_EXT:   tick = ext_tick;
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/gtmr16_presc.sv
module gtmr16_presc
  import gtmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [1:0]       sel,
  output logic             done,
  output logic [PRE_W-1:0] pre_q,
  output logic [PRE_W-1:0] pre_lim
);
  assign pre_lim = presc_limit(sel);
  assign done    = adv & (pre_q >= pre_lim);

  always_ff @(posedge clk) begin
    if (!rst_n)     pre_q <= '0;
    else if (clr)   pre_q <= '0;
    else if (done)  pre_q <= '0;
    else if (adv)   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/gtmr16_gate.sv
module gtmr16_gate
  import gtmr16_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  gate_src_e src,
  input  logic      pol,
  input  logic      tog_md,
  input  logic      one_md,
  input  logic      go_set,
  input  logic      pin_i,
  input  logic      ovf_i,
  input  logic      match_i,
  output logic      qual,
  output logic      go,
  output logic      done
);
  logic p1, p2, raw, g_s, g_d, tff, level, lvl_d, acq, lrise, lfall;

  always_comb begin
    case (src)
      GSRC_PIN:   raw = p2;
      GSRC_OVF:   raw = ovf_i;
      GSRC_MATCH: raw = match_i;
      default:    raw = 1'b0;
    endcase
  end

  assign level = tog_md ? tff : g_s;
  assign lrise = level & ~lvl_d;
  assign lfall = ~level & lvl_d;
  assign done  = acq & lfall;
  assign qual  = one_md ? acq : level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1 <= 1'b0; p2 <= 1'b0; g_s <= 1'b0; g_d <= 1'b0;
      tff <= 1'b0; lvl_d <= 1'b0; acq <= 1'b0; go <= 1'b0;
    end else begin
      p1    <= pin_i;
      p2    <= p1;
      g_s   <= raw ^ pol;
      g_d   <= g_s;
      lvl_d <= level;
      if (!en || !tog_md)    tff <= 1'b0;
      else if (g_s && !g_d)  tff <= ~tff;
      if (!one_md)   acq <= 1'b0;
      else if (acq)  acq <= ~lfall;
      else           acq <= go & lrise;
      if (go_set)    go <= 1'b1;
      else if (done) go <= 1'b0;
    end
  end
endmodule

// File: rtl/gtmr16.sv
module gtmr16
  import gtmr16_pkg::*;
#(
  parameter int INSTR_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        ext_clk_i,
  input  logic        gate_pin_i,
  input  logic        tmr_ovf_evt_i,
  input  logic        tmr_match_evt_i,
  output logic        ovf_flag_o,
  output logic        gate_evt_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [7:0]       ctrl_q;
  logic [5:0]       gcfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BYTE_W-1:0] hi_buf;
  logic             ovf_q, gevt_q;

  // Named events for the checker.
  logic run, wr_ctrl, wr_gate, wr_lo, wr_hi, wr_flag, cnt_wr;
  logic count_en, tick, ext_tick, armed, inc_evt, wrap_evt;
  logic qual, go, gdone;
  logic [PRE_W-1:0] pre_q, pre_lim;

  assign run     = ctrl_q[7];
  assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
  assign wr_gate = bus_wr && bus_addr == ADDR_GATE;
  assign wr_lo   = bus_wr && bus_addr == ADDR_CLO;
  assign wr_hi   = bus_wr && bus_addr == ADDR_CHI;
  assign wr_flag = bus_wr && bus_addr == ADDR_FLAG;
  assign cnt_wr  = wr_lo | wr_hi;
  assign count_en = run & (~gcfg_q[5] | qual);
  assign wrap_evt = inc_evt & at_wrap(cnt_q);

  gtmr16_clksrc #(.DIV(INSTR_DIV)) u_src (
    .clk(clk), .rst_n(rst_n), .run(run), .sync_en(ctrl_q[4]),
    .sel(clk_sel_e'(ctrl_q[1:0])), .adv(count_en), .clr(cnt_wr),
    .ext_i(ext_clk_i), .tick(tick), .ext_tick(ext_tick), .armed(armed)
  );

  gtmr16_presc u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cnt_wr), .adv(count_en & tick),
    .sel(ctrl_q[3:2]), .done(inc_evt), .pre_q(pre_q), .pre_lim(pre_lim)
  );

  gtmr16_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(gcfg_q[5]), .src(gate_src_e'(gcfg_q[1:0])),
    .pol(gcfg_q[2]), .tog_md(gcfg_q[3]), .one_md(gcfg_q[4]),
    .go_set(wr_gate & bus_wdata[5]), .pin_i(gate_pin_i),
    .ovf_i(tmr_ovf_evt_i), .match_i(tmr_match_evt_i),
    .qual(qual), .go(go), .done(gdone)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; gcfg_q <= '0; cnt_q <= '0; hi_buf <= '0;
      ovf_q <= 1'b0; gevt_q <= 1'b0; bus_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_gate) gcfg_q <= {bus_wdata[7], bus_wdata[4:0]};
      if (cnt_wr) begin
        if (wr_lo) cnt_q[BYTE_W-1:0]     <= bus_wdata;
        if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= bus_wdata;
      end else if (inc_evt) begin
        cnt_q <= cnt_q + 1'b1;
      end
      ovf_q  <= wrap_evt | (ovf_q  & ~(wr_flag & bus_wdata[0]));
      gevt_q <= gdone    | (gevt_q & ~(wr_flag & bus_wdata[1]));
      if (bus_rd) begin
        case (bus_addr)
          ADDR_CTRL: bus_rdata <= ctrl_q;
          ADDR_GATE: bus_rdata <= {gcfg_q[5], qual, go, gcfg_q[4:0]};
          ADDR_CLO: begin
            bus_rdata <= cnt_q[BYTE_W-1:0];
            hi_buf    <= cnt_q[CNT_W-1:BYTE_W];
          end
          ADDR_CHI:  bus_rdata <= hi_buf;
          ADDR_FLAG: bus_rdata <= {6'b0, gevt_q, ovf_q};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  assign ovf_flag_o = ovf_q;
  assign gate_evt_o = gevt_q;
endmodule

// File: rtl/gtmr16_chk.sv
module gtmr16_chk #(
  parameter int CW = 16,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt,
  input logic          inc,
  input logic          ovf_flag,
  input logic          ext_tick,
  input logic          armed,
  input logic          go,
  input logic          gevt,
  input logic [PW-1:0] pre,
  input logic [PW-1:0] pre_lim
);
  a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  a_r10_step_or_load: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1'b1)));

  a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (&cnt) && !cnt_wr) |=> (ovf_flag && cnt == '0));

  a_r3_ext_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |-> armed);

  a_r6_go_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> gevt);

  a_r2_presc_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= pre_lim || $changed(pre_lim));
endmodule

bind gtmr16 gtmr16_chk #(.CW(2 * gtmr16_pkg::BYTE_W), .PW(gtmr16_pkg::PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt_wr(cnt_wr), .cnt(cnt_q),
  .inc(inc_evt), .ovf_flag(ovf_flag_o), .ext_tick(ext_tick), .armed(armed),
  .go(go), .gevt(gate_evt_o), .pre(pre_q), .pre_lim(pre_lim)
);

// File: tb/gtmr16_test.sv
`timescale 1ns/1ps
module gtmr16_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic ext_clk_i = 1'b0, gate_pin_i = 1'b0, tmr_ovf_evt_i = 1'b0, tmr_match_evt_i = 1'b0;
  logic ovf_flag_o, gate_evt_o;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gtmr16 uut (.*);

  // {clksel[2], presc[2], cycles[12], expected[16]}
  localparam logic [31:0] VEC [7] = '{
    {2'b01, 2'b00, 12'd20, 16'd20},
    {2'b01, 2'b01, 12'd20, 16'd10},
    {2'b01, 2'b10, 12'd21, 16'd5},
    {2'b01, 2'b11, 12'd40, 16'd5},
    {2'b00, 2'b00, 12'd20, 16'd5},
    {2'b00, 2'b01, 12'd33, 16'd4},
    {2'b11, 2'b00, 12'd20, 16'd0}
  };

  task automatic check(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] lo, hi;
    rd(3'd2, lo);
    rd(3'd3, hi);
    v = {hi, lo};
  endtask

  task automatic clear_cnt();
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
  endtask

  task automatic pulse_ovf();
    tmr_ovf_evt_i = 1'b1; @(negedge clk); tmr_ovf_evt_i = 1'b0;
  endtask

  task automatic pulse_match();
    tmr_match_evt_i = 1'b1; @(negedge clk); tmr_match_evt_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired got 0 expected 1");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int v;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R11 reset state
    rd(3'd0, d); check("R11 ctrl", d, 0);
    rd_cnt(v);   check("R11 count", v, 0);
    rd(3'd4, d); check("R11 flags", d, 0);
    check("R11 flag pins", {ovf_flag_o, gate_evt_o}, 0);

    // R1/R2 source and prescaler table
    for (int i = 0; i < 7; i++) begin
      logic [7:0] c;
      c = {4'b0000, VEC[i][29:28], VEC[i][31:30]};
      clear_cnt();
      wr(3'd0, c | 8'h80);
      idle(int'(VEC[i][27:16]) - 1);
      wr(3'd0, c);
      rd_cnt(v);
      check($sformatf("R1 R2 vector %0d", i), v, int'(VEC[i][15:0]));
    end

    // R2 prescaler phase kept across stop
    clear_cnt();
    wr(3'd0, 8'h8D); idle(4); wr(3'd0, 8'h0D);
    wr(3'd0, 8'h8D); idle(3); wr(3'd0, 8'h0D);
    rd_cnt(v); check("R2 phase retained", v, 1);
    // R10 counter write clears the phase
    clear_cnt();
    wr(3'd0, 8'h8D); idle(4); wr(3'd0, 8'h0D);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h8D); idle(3); wr(3'd0, 8'h0D);
    rd_cnt(v); check("R10 write clears prescaler", v, 0);

    // R3 external clock, synchronised, starting low: first rise ignored
    clear_cnt();
    wr(3'd0, 8'h92); idle(3);
    for (int k = 0; k < 4; k++) begin
      ext_clk_i = 1'b1; idle(3); ext_clk_i = 1'b0; idle(3);
    end
    idle(6); wr(3'd0, 8'h12);
    rd_cnt(v); check("R3 ext sync", v, 3);
    // R3 external clock, one stage, starting high
    ext_clk_i = 1'b1; idle(4);
    clear_cnt();
    wr(3'd0, 8'h82); idle(3);
    for (int k = 0; k < 4; k++) begin
      ext_clk_i = 1'b0; idle(3); ext_clk_i = 1'b1; idle(3);
    end
    idle(6); wr(3'd0, 8'h02);
    rd_cnt(v); check("R3 ext no sync", v, 4);
    ext_clk_i = 1'b0;

    // R4/R8 pin gate, active high
    wr(3'd1, 8'h80); clear_cnt();
    wr(3'd0, 8'h81); idle(5);
    gate_pin_i = 1'b1; idle(4);
    rd(3'd1, d); check("R8 gate value high", d[6], 1);
    idle(2); gate_pin_i = 1'b0; idle(6);
    rd(3'd1, d); check("R8 gate value low", d[6], 0);
    wr(3'd0, 8'h01);
    rd_cnt(v); check("R4 pin gate high", v, 7);

    // R4 inverted polarity
    gate_pin_i = 1'b1; wr(3'd1, 8'h84); idle(5); clear_cnt();
    wr(3'd0, 8'h81); idle(5);
    gate_pin_i = 1'b0; idle(6); gate_pin_i = 1'b1; idle(6);
    wr(3'd0, 8'h01);
    rd_cnt(v); check("R4 pin gate low", v, 6);
    gate_pin_i = 1'b0;

    // R4 gate disabled: pin ignored
    wr(3'd1, 8'h00); clear_cnt();
    wr(3'd0, 8'h81); idle(3);
    gate_pin_i = 1'b1; idle(3); gate_pin_i = 1'b0; idle(8);
    wr(3'd0, 8'h01);
    rd_cnt(v); check("R4 gate off", v, 15);

    // R4 match source; overflow pulses ignored
    wr(3'd1, 8'h82); idle(3); clear_cnt();
    wr(3'd0, 8'h81); idle(2);
    for (int k = 0; k < 3; k++) begin
      pulse_match(); idle(2); pulse_ovf(); idle(2);
    end
    idle(4); wr(3'd0, 8'h01);
    rd_cnt(v); check("R4 match source", v, 3);

    // R4 no source
    wr(3'd1, 8'h83); idle(3); clear_cnt();
    wr(3'd0, 8'h81);
    pulse_match(); pulse_ovf(); gate_pin_i = 1'b1; idle(5); gate_pin_i = 1'b0; idle(4);
    wr(3'd0, 8'h01);
    rd_cnt(v); check("R4 no source", v, 0);

    // R5 toggle mode on overflow pulses
    wr(3'd1, 8'h89); idle(3); clear_cnt();
    wr(3'd0, 8'h81); idle(2);
    pulse_ovf(); idle(8); pulse_ovf(); idle(6);
    wr(3'd0, 8'h01);
    rd_cnt(v); check("R5 toggle period", v, 9);

    // R6 single pulse acquisition
    wr(3'd1, 8'h90); idle(4); clear_cnt();
    wr(3'd1, 8'hB0);
    rd(3'd1, d); check("R6 go armed", d[5], 1);
    wr(3'd0, 8'h81); idle(3);
    gate_pin_i = 1'b1; idle(5); gate_pin_i = 1'b0; idle(4);
    gate_pin_i = 1'b1; idle(3); gate_pin_i = 1'b0; idle(5);
    wr(3'd0, 8'h01);
    rd_cnt(v); check("R6 single pulse width", v, 5);
    rd(3'd1, d); check("R6 go self cleared", d[5], 0);
    rd(3'd4, d); check("R6 gate event flag", d[1], 1);
    check("R6 gate event pin", gate_evt_o, 1);
    wr(3'd4, 8'h02);
    rd(3'd4, d); check("R7 gate event cleared", d, 0);
    wr(3'd1, 8'h00);

    // R7 overflow
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h81); wr(3'd0, 8'h01);
    rd_cnt(v); check("R7 wrap to zero", v, 0);
    idle(5);
    rd(3'd4, d); check("R7 overflow sticky", d, 1);
    check("R7 overflow pin", ovf_flag_o, 1);
    wr(3'd4, 8'h01);
    rd(3'd4, d); check("R7 overflow cleared", d, 0);

    // R9 coherent read while running
    wr(3'd2, 8'hFE); wr(3'd3, 8'h01);
    wr(3'd0, 8'h81);
    rd(3'd2, d); check("R9 low byte", d, 8'hFE);
    idle(4);
    rd(3'd3, d); check("R9 latched high byte", d, 8'h01);
    wr(3'd0, 8'h01);
    rd_cnt(v); check("R9 final count", v, 16'h0205);

    finish_run();
  end
endmodule